// File: doc/BRIEF.md
# Multiplier and Scratch Register Port

This peripheral sits on a byte-wide processor bus inside an expansion address window. It holds two 8-bit operand registers whose unsigned product is always available on the read side, split into a low byte and a high byte at two separate sub-addresses. It also holds one general-purpose scratch byte that software can write and read back, and it offers a read-only window that reports the state of two configuration switches.

The upper 2 KB of the window (offsets 0x1800 to 0x1FFF) hold the registers, decoded only by offset bits 2:0, so each register repeats every 8 bytes. The 2 KB below it (0x1000 to 0x17FF) is the switch window. Any read that selects no register returns the value last seen on the bus, which the system supplies on a separate input. Writes land on the rising clock edge. Reads are combinational from the registered state, so a read in the same cycle as a write returns the value held before that write.

Top module: `mul_scratch_port`

## Requirements
- R1: After reset, operands and scratch byte are zero: reads of sub-addresses 0, 1 and 3 in the register area return 0x00.
- R2: A write to register-area sub-address 0 loads operand A, and a write to sub-address 1 loads operand B.
- R3: A read of sub-address 0 returns bits 7:0 of the unsigned product A×B.
- R4: A read of sub-address 1 returns bits 15:8 of the unsigned product A×B.
- R5: A write to sub-address 3 stores the scratch byte, and a later read of sub-address 3 returns it.
- R6: Only offset bits 2:0 select a register inside 0x1800–0x1FFF, so, for example, 0x1FF8 acts the same as 0x1800.
- R7: A read in 0x1000–0x17FF returns the two switch bits in data bits 7:6 (switch input bit 1 in bit 7) and bus_last bits 5:0 in data bits 5:0.
- R8: A read below 0x1000 returns bus_last unchanged, and writes below 0x1800 change no register.
- R9: Sub-addresses 2 and 4 to 7 of the register area ignore writes and return bus_last on reads.
- R10: When rd_en is low, rdata equals bus_last.
- R11: A read and a write in the same cycle return the register contents from before that write. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Byte offset inside the expansion window |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| bus_last | input | 8 | Last value seen on the data bus |
| switches | input | 2 | Configuration switch state |
| rdata | output | 8 | Read data |

## Verification
A write that loads an operand or the scratch byte can come in the same cycle as a read of the product or of the scratch byte. The bench drives both strobes together on one address. It checks that the read taken before the clock edge shows the old contents and that a read in the next cycle shows the new contents, using product values worked out in the bench. Random traffic also mixes aliased register addresses, the switch window and unmapped offsets with changing bus_last values, so decode and open-bus merging are checked while register contents change.

// File: rtl/mul_scratch_port.sv
module mul_scratch_port #(
  parameter int OFS_W  = 13,
  parameter int DATA_W = 8,
  parameter int SW_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_last,
  input  logic [SW_W-1:0]   switches,
  output logic [DATA_W-1:0] rdata
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUB_W  = 3;

  logic [DATA_W-1:0] op_a, op_b, scratch;
  logic [PROD_W-1:0] product;
  logic              in_regs, in_sw;
  logic [SUB_W-1:0]  sub;

  assign in_regs = addr[OFS_W-1 -: 2] == 2'b11;
  assign in_sw   = addr[OFS_W-1 -: 2] == 2'b10;
  assign sub     = addr[SUB_W-1:0];
  assign product = op_a * op_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a    <= '0;
      op_b    <= '0;
      scratch <= '0;
    end else if (wr_en && in_regs) begin
      case (sub)
        3'd0: op_a    <= wdata;
        3'd1: op_b    <= wdata;
        3'd3: scratch <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = bus_last;
    if (rd_en) begin
      if (in_sw)
        rdata = {switches, bus_last[DATA_W-SW_W-1:0]};
      else if (in_regs) begin
        case (sub)
          3'd0: rdata = product[DATA_W-1:0];
          3'd1: rdata = product[PROD_W-1:DATA_W];
          3'd3: rdata = scratch;
          default: rdata = bus_last;
        endcase
      end
    end
  end
endmodule

module mul_scratch_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  bus_last,
  input logic [1:0]  switches,
  input logic [7:0]  rdata
);
  logic regs_win, sw_win, scr_wr, scr_rd;
  assign regs_win = addr[12:11] == 2'b11;
  assign sw_win   = addr[12:11] == 2'b10;
  assign scr_wr   = wr_en && regs_win && addr[2:0] == 3'd3;
  assign scr_rd   = rd_en && !wr_en && regs_win && addr[2:0] == 3'd3;

  // R5
  scratch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |=> (!scr_rd || rdata == $past(wdata)));

  // R7
  switch_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sw_win) |-> (rdata[7:6] == switches && rdata[5:0] == bus_last[5:0]));

  // R8
  low_open_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr[12]) |-> rdata == bus_last);

  // R9
  unused_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && regs_win && (addr[2:0] == 3'd2 || addr[2]))
      |-> rdata == bus_last);

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == bus_last);
endmodule

bind mul_scratch_port mul_scratch_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .bus_last(bus_last), .switches(switches), .rdata(rdata)
);

// File: tb/sim_mul_scratch_port.sv
module sim_mul_scratch_port;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0, bus_last = 8'h5A, rdata;
  logic [1:0]  switches = 2'b10;
  int checks = 0, fails = 0;
  logic [7:0] m_a = 0, m_b = 0, m_l = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mul_scratch_port u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .bus_last(bus_last), .switches(switches), .rdata(rdata));

  function automatic logic [7:0] exp_rd(logic [12:0] a, logic [7:0] bl, logic [1:0] sw);
    logic [15:0] p = m_a * m_b;
    if (a[12:11] == 2'b10) return {sw, bl[5:0]};
    if (a[12:11] != 2'b11) return bl;
    case (a[2:0])
      3'd0: return p[7:0];
      3'd1: return p[15:8];
      3'd3: return m_l;
      default: return bl;
    endcase
  endfunction

  function automatic void model_wr(logic [12:0] a, logic [7:0] d);
    if (a[12:11] == 2'b11)
      case (a[2:0])
        3'd0: m_a = d;
        3'd1: m_b = d;
        3'd3: m_l = d;
        default: ;
      endcase
  endfunction

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, rdata, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1; rd_en = 0;
    @(posedge clk); model_wr(a, d);
    #1 wr_en = 0;
  endtask

  task automatic rd(logic [12:0] a, string req);
    @(negedge clk); addr = a; rd_en = 1; wr_en = 0;
    #2 check(req, exp_rd(a, bus_last, switches));
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(13'h1800, "R1"); rd(13'h1801, "R1"); rd(13'h1803, "R1");
    // R2 R3 R4 directed corners
    wr(13'h1800, 8'hFF); wr(13'h1801, 8'hFF);
    rd(13'h1800, "R3"); rd(13'h1801, "R4");
    wr(13'h1800, 8'h00); rd(13'h1801, "R2");
    wr(13'h1800, 8'h10); wr(13'h1801, 8'h10); rd(13'h1801, "R4");
    // R5
    wr(13'h1803, 8'hC3); rd(13'h1803, "R5");
    // R6 aliasing
    wr(13'h1FF8, 8'h07); wr(13'h1AB9, 8'h0B); rd(13'h1800, "R6"); rd(13'h1FF1, "R6");
    wr(13'h1FFB, 8'h3C); rd(13'h180B, "R6");
    // R7
    bus_last = 8'h3F; switches = 2'b01; rd(13'h1000, "R7");
    bus_last = 8'hC0; switches = 2'b10; rd(13'h17FF, "R7");
    // R8 low reads and ignored writes
    bus_last = 8'h96; rd(13'h0123, "R8");
    wr(13'h1000, 8'hEE); wr(13'h0003, 8'hEE); wr(13'h1403, 8'hEE);
    rd(13'h1800, "R8"); rd(13'h1803, "R8");
    // R9 unused sub-addresses
    for (int s = 4; s < 8; s++) wr(13'h1800 | 13'(s), 8'hAA);
    wr(13'h1802, 8'hAA);
    rd(13'h1802, "R9"); rd(13'h1806, "R9"); rd(13'h1800, "R9"); rd(13'h1801, "R9"); rd(13'h1803, "R9");
    // R10
    @(negedge clk); addr = 13'h1803; rd_en = 0; bus_last = 8'h21;
    #2 check("R10", 8'h21);
    // R11 same-cycle read and write
    @(negedge clk); addr = 13'h1803; wdata = 8'h99; wr_en = 1; rd_en = 1;
    #2 check("R11", m_l);
    @(posedge clk); model_wr(13'h1803, 8'h99);
    @(negedge clk); wr_en = 0;
    #2 check("R11", 8'h99);
    @(negedge clk); addr = 13'h1800; wdata = 8'h05; wr_en = 1; rd_en = 1;
    #2 check("R11", exp_rd(13'h1800, bus_last, switches));
    @(posedge clk); model_wr(13'h1800, 8'h05);
    @(negedge clk); wr_en = 0;
    #2 check("R11", exp_rd(13'h1800, bus_last, switches));
    @(posedge clk); #1 rd_en = 0;
    // random mix, R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic [12:0] a;
      a = 13'($urandom);
      bus_last = 8'($urandom);
      switches = 2'($urandom);
      if ($urandom % 2 == 0) begin
        if ($urandom % 4 != 0) a[12:11] = 2'b11;
        wr(a, 8'($urandom));
      end else begin
        rd(a, "R3/R4 random");
      end
    end
    done = 1;
    finish_run();
  end
endmodule